// File: doc/BRIEF.md
# SDRAM Power-Up Bring-Up Sequencer

This block sits on the controller side of a synchronous DRAM interface. It takes the memory from power-on to a usable state. After a synchronous reset it drives the chip-select, row-strobe, column-strobe and write-enable lines, the clock-enable and data-mask lines, the address bus and the bank-address bus through a fixed bring-up sequence. First comes a long idle pause, then a precharge of all banks, then the mode-register load and a burst of auto-refresh commands. The relative order of the mode-register load and the refresh burst is set by a parameter.

Every wait is counted in clock cycles. The initial pause is derived from a clock-frequency parameter and a pause length in microseconds. The gaps after precharge, refresh and mode load are given in cycles. When the last gap has elapsed the block raises `initDone` and holds the command bus at NOP from then on. The controller that takes over later may then start normal traffic.

Top module: `sdram_bringup_seq`

## Requirements
- R1: From the release of reset until the precharge appears, the command bus {csN,rasN,casN,weN} carries only NOP (4'b0111).
- R2: cke and dqm read 1 during reset, throughout the sequence and after it completes.
- R3: The precharge (4'b0010, with address bit AP_BIT=10 set to select all banks) appears exactly PAUSE_CYC = CLK_MHZ*PAUSE_US cycles after the first rising edge with reset low. This is 25000 cycles at the defaults.
- R4: ba is 0 on every cycle. During the mode-register load (4'b0000) addr equals MODE_WORD. During refresh and NOP addr is 0, and during precharge it holds only bit 10.
- R5: Exactly max(NUM_REFRESH,8) auto-refresh commands (4'b0001) are issued per sequence.
- R6: With REFRESH_FIRST=0 the order is precharge, mode load, refreshes. With REFRESH_FIRST=1 it is precharge, refreshes, mode load.
- R7: If a command is issued at cycle n, the next one is issued at exactly n+T. T is T_RP after precharge, T_RFC after a refresh, and max(T_MRD,2) after the mode load. Only NOP appears in between.
- R8: The cycle right after the mode-register load always carries NOP.
- R9: initDone stays 0 until exactly T cycles after the last command, where T is that command's gap. From then on it stays 1 and the bus stays at NOP until reset.
- R10: A reset asserted at any point, including mid-sequence, clears initDone and restarts the whole sequence from the pause. The precharge then again appears PAUSE_CYC cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data mask |
| addr | output | ADDR_W | Address bus (mode word, all-bank flag) |
| ba | output | BA_W | Bank address |
| initDone | output | 1 | Bring-up sequence complete |

## Verification
The hardest situation to reach is a reset that lands in the middle of the sequence, after the mode load has gone out but before the refresh burst has finished. The sequencer must then discard its refresh count and restart the long pause. The bench watches the command bus, logs each command with its cycle, and pulses reset as soon as the second command is seen. It then checks that the whole timeline repeats exactly. A second instance built with the refresh-first ordering runs alongside, so both orderings are checked against one computed timeline.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command bus encoding: {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  // Next action pending once the running wait expires
  typedef enum logic [2:0] {
    ST_PRE,
    ST_MRS,
    ST_REF,
    ST_FIN,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic doPre;
    logic doMrs;
    logic doRef;
    logic doFin;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int REF_TOTAL     = 8,
  parameter bit REFRESH_FIRST = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       waitZero,
  output seqStrobe_t strobe
);

  localparam int RC_W = $clog2(REF_TOTAL + 1);

  seqState_t       state, nextState;
  logic [RC_W-1:0] refLeft;
  logic            lastRef;

  assign lastRef = (refLeft == RC_W'(1));

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (waitZero) begin
      case (state)
        ST_PRE: begin
          strobe.doPre = 1'b1;
          nextState    = REFRESH_FIRST ? ST_REF : ST_MRS;
        end
        ST_MRS: begin
          strobe.doMrs = 1'b1;
          nextState    = REFRESH_FIRST ? ST_FIN : ST_REF;
        end
        ST_REF: begin
          strobe.doRef = 1'b1;
          if (lastRef) nextState = REFRESH_FIRST ? ST_MRS : ST_FIN;
        end
        ST_FIN: begin
          strobe.doFin = 1'b1;
          nextState    = ST_DONE;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_PRE;
      refLeft <= RC_W'(REF_TOTAL);
    end else begin
      state <= nextState;
      if (strobe.doRef) refLeft <= refLeft - RC_W'(1);
    end
  end

  // R7: at most one action per cycle
  p_single_action_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.doPre, strobe.doMrs, strobe.doRef, strobe.doFin}));

  // R5: never issue a refresh beyond the budget
  p_ref_budget_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.doRef |-> (refLeft != '0));

  // R9: the finished state is terminal until reset
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_DONE));

endmodule

// File: rtl/sdram_init_dpath.sv
module sdram_init_dpath
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int AP_BIT    = 10,
  parameter int PAUSE_CYC = 25000,
  parameter int GAP_RP    = 3,
  parameter int GAP_RFC   = 9,
  parameter int GAP_MRD   = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  output logic              waitZero,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic              dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              initDone
);

  localparam int MAX_A    = (GAP_RP > GAP_RFC) ? GAP_RP : GAP_RFC;
  localparam int MAX_B    = (MAX_A > GAP_MRD) ? MAX_A : GAP_MRD;
  localparam int MAX_WAIT = (PAUSE_CYC > MAX_B) ? PAUSE_CYC : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  logic [CNT_W-1:0]  waitCnt;
  logic [3:0]        cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic              doneQ;
  logic              inPause;

  assign waitZero = (waitCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      waitCnt <= CNT_W'(PAUSE_CYC - 1);
      cmdQ    <= CMD_NOP;
      addrQ   <= '0;
      doneQ   <= 1'b0;
      inPause <= 1'b1;
    end else begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      if (strobe.doPre) begin
        cmdQ    <= CMD_PRE;
        addrQ   <= AP_MASK;
        waitCnt <= CNT_W'(GAP_RP - 1);
        inPause <= 1'b0;
      end else if (strobe.doMrs) begin
        cmdQ    <= CMD_MRS;
        addrQ   <= MODE_WORD;
        waitCnt <= CNT_W'(GAP_MRD - 1);
      end else if (strobe.doRef) begin
        cmdQ    <= CMD_REF;
        waitCnt <= CNT_W'(GAP_RFC - 1);
      end else if (strobe.doFin) begin
        doneQ <= 1'b1;
      end else if (!waitZero) begin
        waitCnt <= waitCnt - CNT_W'(1);
      end
    end
  end

  assign {csN, rasN, casN, weN} = cmdQ;
  assign addr     = addrQ;
  assign ba       = '0;
  assign cke      = 1'b1;
  assign dqm      = 1'b1;
  assign initDone = doneQ;

  // R1: nothing but NOP while the pause is running
  p_pause_nop_r1: assert property (@(posedge clk) disable iff (rst)
    inPause |-> (cmdQ == CMD_NOP));

  // R3: precharge always addresses every bank
  p_pre_allbanks_r3: assert property (@(posedge clk) disable iff (rst)
    (cmdQ == CMD_PRE) |-> addrQ[AP_BIT]);

  // R4: mode load carries the configured word
  p_mrs_word_r4: assert property (@(posedge clk) disable iff (rst)
    (cmdQ == CMD_MRS) |-> (addrQ == MODE_WORD));

  // R8: a standby cycle follows the mode load
  p_mrs_standby_r8: assert property (@(posedge clk) disable iff (rst)
    (cmdQ == CMD_MRS) |=> (cmdQ == CMD_NOP));

  // R7: while a wait runs, the next cycle is NOP
  p_gap_nop_r7: assert property (@(posedge clk) disable iff (rst)
    !waitZero |=> (cmdQ == CMD_NOP));

  // R9: once done, stay done and quiet
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> (doneQ && cmdQ == CMD_NOP));

endmodule

// File: rtl/sdram_bringup_seq.sv
module sdram_bringup_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ       = 125,
  parameter int PAUSE_US      = 200,
  parameter int T_RP          = 3,
  parameter int T_RFC         = 9,
  parameter int T_MRD         = 2,
  parameter int NUM_REFRESH   = 8,
  parameter bit REFRESH_FIRST = 1'b0,
  parameter int ADDR_W        = 13,
  parameter int BA_W          = 2,
  parameter int AP_BIT        = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 13'h0032
) (
  input  logic              clk,
  input  logic              rst,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic              dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              initDone
);

  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int GAP_RP    = (T_RP < 1) ? 1 : T_RP;
  localparam int GAP_RFC   = (T_RFC < 1) ? 1 : T_RFC;
  localparam int GAP_MRD   = (T_MRD < 2) ? 2 : T_MRD;
  localparam int REF_TOTAL = (NUM_REFRESH < 8) ? 8 : NUM_REFRESH;

  seqStrobe_t strobe;
  logic       waitZero;

  sdram_init_ctrl #(
    .REF_TOTAL    (REF_TOTAL),
    .REFRESH_FIRST(REFRESH_FIRST)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .waitZero(waitZero),
    .strobe  (strobe)
  );

  sdram_init_dpath #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .AP_BIT   (AP_BIT),
    .PAUSE_CYC(PAUSE_CYC),
    .GAP_RP   (GAP_RP),
    .GAP_RFC  (GAP_RFC),
    .GAP_MRD  (GAP_MRD),
    .MODE_WORD(MODE_WORD)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .waitZero(waitZero),
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .cke     (cke),
    .dqm     (dqm),
    .addr    (addr),
    .ba      (ba),
    .initDone(initDone)
  );

endmodule

// File: tb/tb_sdram_bringup_seq.sv
module tb_sdram_bringup_seq;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int P      = 125 * 200;
  localparam int T_RP   = 3;
  localparam int T_RFC  = 9;
  localparam int G_MRD  = 2;
  localparam int NREF   = 8;
  localparam logic [ADDR_W-1:0] MODE = 13'h0032;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic csN0, rasN0, casN0, weN0, cke0, dqm0, done0;
  logic csN1, rasN1, casN1, weN1, cke1, dqm1, done1;
  logic [ADDR_W-1:0] addr0, addr1;
  logic [BA_W-1:0]   ba0, ba1;

  sdram_bringup_seq #(.REFRESH_FIRST(1'b0)) dut (
    .clk(clk), .rst(rst), .csN(csN0), .rasN(rasN0), .casN(casN0), .weN(weN0),
    .cke(cke0), .dqm(dqm0), .addr(addr0), .ba(ba0), .initDone(done0));

  sdram_bringup_seq #(.REFRESH_FIRST(1'b1)) dutAlt (
    .clk(clk), .rst(rst), .csN(csN1), .rasN(rasN1), .casN(casN1), .weN(weN1),
    .cke(cke1), .dqm(dqm1), .addr(addr1), .ba(ba1), .initDone(done1));

  logic [3:0]        cmdS [2];
  logic [ADDR_W-1:0] addrS[2];
  logic [BA_W-1:0]   baS  [2];
  logic              ckeS [2], dqmS[2], doneS[2];
  assign cmdS[0] = {csN0, rasN0, casN0, weN0};
  assign cmdS[1] = {csN1, rasN1, casN1, weN1};
  assign addrS[0] = addr0; assign addrS[1] = addr1;
  assign baS[0] = ba0;     assign baS[1] = ba1;
  assign ckeS[0] = cke0;   assign ckeS[1] = cke1;
  assign dqmS[0] = dqm0;   assign dqmS[1] = dqm1;
  assign doneS[0] = done0; assign doneS[1] = done1;

  int cyc;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  logic [3:0] evCmd[2][16];
  int  evCyc[2][16];
  int  evN[2], doneCyc[2];
  bit  badPause[2], badCke[2], badBa[2], badAddr[2], doneDrop[2], busyAfter[2];

  int checks = 0, fails = 0;

  always @(negedge clk) begin
    for (int w = 0; w < 2; w++) begin
      if (rst) begin
        evN[w] = 0; doneCyc[w] = -1;
        badPause[w] = 0; badCke[w] = 0; badBa[w] = 0;
        badAddr[w] = 0; doneDrop[w] = 0; busyAfter[w] = 0;
      end else begin
        logic [ADDR_W-1:0] ea;
        ea = (cmdS[w] == PRE) ? ADDR_W'(1) << 10 : (cmdS[w] == MRS) ? MODE : '0;
        if (addrS[w] !== ea) badAddr[w] = 1;
        if (baS[w] !== '0) badBa[w] = 1;
        if (ckeS[w] !== 1'b1 || dqmS[w] !== 1'b1) badCke[w] = 1;
        if (cmdS[w] != NOP) begin
          if (evN[w] == 0 && cyc < P) badPause[w] = 1;
          if (doneCyc[w] >= 0) busyAfter[w] = 1;
          if (evN[w] < 16) begin
            evCmd[w][evN[w]] = cmdS[w];
            evCyc[w][evN[w]] = cyc;
          end
          evN[w]++;
        end
        if (doneS[w] === 1'b1 && doneCyc[w] < 0) doneCyc[w] = cyc;
        if (doneCyc[w] >= 0 && doneS[w] !== 1'b1) doneDrop[w] = 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitBothDone();
    while (!(done0 === 1'b1 && done1 === 1'b1)) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // R2 / R9 / R10: outputs while reset is held
  task automatic testResetState(string req);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int w = 0; w < 2; w++) begin
      chk(cmdS[w] == NOP, req, "cmd in reset", int'(cmdS[w]), int'(NOP));
      chk(doneS[w] == 1'b0, req, "initDone in reset", int'(doneS[w]), 0);
      chk(ckeS[w] && dqmS[w], "R2", "cke&dqm in reset", int'({ckeS[w], dqmS[w]}), 3);
    end
    rst = 1'b0;
  endtask

  // R1 R3 R4 R5 R6 R7 R8 R9 for one instance
  task automatic checkSequence(int w, string tag);
    int t, k, nref;
    bit rf;
    logic [3:0] expC[10];
    int expT[10];
    rf = (w == 1);
    t = P; k = 0;
    expC[k] = PRE; expT[k] = t; k++; t += T_RP;
    if (!rf) begin
      expC[k] = MRS; expT[k] = t; k++; t += G_MRD;
    end
    for (int i = 0; i < NREF; i++) begin
      expC[k] = REF; expT[k] = t; k++; t += T_RFC;
    end
    if (rf) begin
      expC[k] = MRS; expT[k] = t; k++; t += G_MRD;
    end
    chk(evN[w] == 10, "R5", {tag, " command count"}, evN[w], 10);
    nref = 0;
    for (int i = 0; i < 10 && i < evN[w]; i++) begin
      if (evCmd[w][i] == REF) nref++;
      chk(evCmd[w][i] == expC[i], "R6", {tag, " command order"}, int'(evCmd[w][i]), int'(expC[i]));
      chk(evCyc[w][i] == expT[i], (i == 0) ? "R3" : "R7", {tag, " command cycle"}, evCyc[w][i], expT[i]);
      if (evCmd[w][i] == MRS && i + 1 < evN[w])
        chk(evCyc[w][i+1] > evCyc[w][i] + 1, "R8", {tag, " standby after mode load"},
            evCyc[w][i+1] - evCyc[w][i], G_MRD);
    end
    chk(nref == NREF, "R5", {tag, " refresh count"}, nref, NREF);
    chk(doneCyc[w] == t, "R9", {tag, " initDone cycle"}, doneCyc[w], t);
    chk(!badPause[w], "R1", {tag, " non-NOP during pause"}, int'(badPause[w]), 0);
    chk(!badCke[w], "R2", {tag, " cke/dqm low"}, int'(badCke[w]), 0);
    chk(!badBa[w] && !badAddr[w], "R4", {tag, " address/bank fields"},
        int'({badBa[w], badAddr[w]}), 0);
    chk(!doneDrop[w] && !busyAfter[w], "R9", {tag, " quiet after done"},
        int'({doneDrop[w], busyAfter[w]}), 0);
  endtask

  task automatic testFullSequence();
    waitBothDone();
    checkSequence(0, "mode-first");
    checkSequence(1, "refresh-first");
  endtask

  // R10: reset lands after the mode load, before refreshes complete
  task automatic testMidReset();
    testResetState("R10");
    while (evN[0] < 2) @(negedge clk);
    chk(done0 == 1'b0, "R10", "initDone mid-sequence", int'(done0), 0);
    testResetState("R10");
    repeat (100) @(negedge clk);
    chk(evN[0] == 0 && evN[1] == 0, "R10", "commands soon after restart", evN[0] + evN[1], 0);
    waitBothDone();
    checkSequence(0, "R10 restart mode-first");
    checkSequence(1, "R10 restart refresh-first");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=initDone");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testResetState("R9");
    testFullSequence();
    testMidReset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule